// File: doc/BRIEF.md
# Bit-Select GEMV Reduction Lane

This block is a single lane of a matrix-vector engine. On each accepted transfer it takes a vector of 32 signed 4-bit weights and, for each of the 32 broadcast feature values, four operands. Each operand is a copy of the feature mantissa shifted left by the position of one weight bit. The feature mantissas are already fixed-point numbers aligned to a common exponent. The lane needs no multipliers. Each product is built by adding the operands whose weight bit is set. The operand for the sign bit is subtracted, so each weight acts as a two's-complement value.

The 32 products go into a registered binary adder tree of five levels. A valid flag travels beside the data through every level. The tree output is added into an accumulator. When the programmed number of vectors has been summed, the lane presents the total with a one-cycle valid pulse and starts the next group from zero. Weights arrive under a valid/ready handshake. Ready requires both the lane enable and the feature-ready signal. Dropping the enable discards all work in progress.

Top module: `gemv_lane`

## Requirements
- R1: While `rst` is high at a clock edge, every pipeline register, valid flag, vector counter and the accumulator are cleared, so `res_valid` and `res_data` read 0 after reset.
- R2: `w_ready` is high exactly when `lane_en` and `feat_ready` are both high. A vector is consumed on a rising edge where `w_valid` and `w_ready` are both high.
- R3: Weight i occupies `w_data[4i+3:4i]` in two's complement (-8..7). Operand b of feature i occupies `feat_ops[(4i+b)*11 +: 11]`, signed. The product for input i is the sum of operands 0..2 whose weight bit is set, minus operand 3 if bit 3 is set. With operands equal to the mantissa shifted left by b, this equals mantissa times weight.
- R4: A result is the sum of all 32 products of every vector in its group, as a signed 35-bit value. This holds for extreme inputs, such as all weights -8 with all mantissas -128.
- R5: With a count of 1, `res_valid` is high for one cycle exactly 6 clock edges after the consuming edge.
- R6: `num_vec` gives the number of vectors summed per result, and 0 acts as 1. Each result is a single-cycle pulse. The next group starts with the following consumed vector.
- R7: One vector per cycle is sustained. Idle cycles between vectors do not change any result.
- R8: While `feat_ready` is low, `w_valid` is ignored, and no result comes from those cycles.
- R9: While `lane_en` is low, nothing is consumed. Vectors in flight and a partially summed group are discarded, and `res_valid` is low from the next cycle on.
- R10: After a result is emitted, the accumulator holds zero. The next result contains only the vectors of its own group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | 1 | Lane enable; low flushes and blocks the lane |
| num_vec | input | 17 | Vectors per result (0 treated as 1) |
| feat_ready | input | 1 | Feature operands valid for this cycle |
| feat_ops | input | 1408 | 32 x 4 shifted feature operands, 11 bits each |
| w_valid | input | 1 | Weight vector offered |
| w_data | input | 128 | 32 signed 4-bit weights |
| w_ready | output | 1 | Lane can take a weight vector |
| res_data | output | 35 | Accumulated dot product |
| res_valid | output | 1 | One-cycle result strobe |

## Verification
If a weight bit drives the wrong operand, or the wrong sign, the error shows up in the very next result, 6 edges after the vector enters. The sweep moves every weight value through every input position, so the faulty product value is exposed. A valid flag lost or duplicated in the tree changes either the number of result pulses or their timing against the count. A counter or accumulator that fails to clear shows up one group later, as a result containing vectors from the group before it or as a pulse in the wrong place. The bench checks both cases with consecutive groups and with a flush in the middle of a group.

// File: rtl/gemv_lane_pkg.sv
package gemv_lane_pkg;

  // operand width for a mantissa width: room for a shift of up to 3
  function automatic int operand_width(int mant_w);
    return mant_w + 3;
  endfunction

  // product width: three additions plus one subtraction of operands
  function automatic int product_width(int opw);
    return opw + 2;
  endfunction

  // tree output width: one bit per halving level
  function automatic int tree_width(int pw, int n);
    return pw + $clog2(n);
  endfunction

endpackage

// File: rtl/gemv_lane_bitsel.sv
module gemv_lane_bitsel #(
  parameter int N   = 32,
  parameter int WB  = 4,
  parameter int OPW = 11,
  parameter int PW  = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_fire,
  input  logic [N*WB-1:0]     w_data,
  input  logic [N*WB*OPW-1:0] ops,
  output logic [N*PW-1:0]     prods,
  output logic               prod_vld
);

  for (genvar i = 0; i < N; i++) begin : g_in
    logic signed [PW-1:0]  sum_c;
    logic signed [OPW-1:0] opv;

    always_comb begin
      sum_c = '0;
      opv   = '0;
      for (int b = 0; b < WB; b++) begin
        opv = ops[(i*WB+b)*OPW +: OPW];
        if (w_data[i*WB+b]) begin
          if (b == WB-1) sum_c = sum_c - PW'(opv);
          else           sum_c = sum_c + PW'(opv);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)          prods[i*PW +: PW] <= '0;
      else if (in_fire) prods[i*PW +: PW] <= sum_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) prod_vld <= 1'b0;
    else              prod_vld <= in_fire;
  end

  AST_IDLE_NO_PROD: assert property (@(posedge clk) disable iff (rst)
    !in_fire |=> !prod_vld); // R2

endmodule

// File: rtl/gemv_lane_tree.sv
module gemv_lane_tree #(
  parameter int N  = 32,
  parameter int PW = 13,
  parameter int SW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [N*PW-1:0] leaves,
  input  logic          leaf_vld,
  output logic [SW-1:0]   root,
  output logic          root_vld
);

  localparam int LV    = $clog2(N);
  localparam int NODES = N - 1;

  // heap layout: node k has children 2k+1 and 2k+2; indices >= NODES are leaves
  logic signed [SW-1:0] node [0:NODES-1];
  logic signed [SW-1:0] all_v [0:2*N-2];
  logic [LV-1:0]        vpipe;

  always_comb begin
    for (int k = 0; k < NODES; k++) all_v[k] = node[k];
    for (int j = 0; j < N; j++)
      all_v[NODES+j] = SW'($signed(leaves[j*PW +: PW]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NODES; k++) node[k] <= '0;
    end else begin
      for (int k = 0; k < NODES; k++) node[k] <= all_v[2*k+1] + all_v[2*k+2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vpipe <= '0;
    end else begin
      vpipe[0] <= leaf_vld;
      for (int l = 1; l < LV; l++) vpipe[l] <= vpipe[l-1];
    end
  end

  assign root     = node[0];
  assign root_vld = vpipe[LV-1];

  AST_TREE_SOURCED: assert property (@(posedge clk) disable iff (rst)
    $rose(vpipe[0]) |-> $past(leaf_vld)); // R7

endmodule

// File: rtl/gemv_lane_accum.sv
module gemv_lane_accum #(
  parameter int SW = 18,
  parameter int CW = 17,
  parameter int AW = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [SW-1:0]   sum_in,
  input  logic          sum_vld,
  input  logic [CW-1:0]   target,
  output logic [AW-1:0]   res_data,
  output logic          res_valid
);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_next;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        last_idx;
  logic                 at_last;

  assign last_idx = (target == '0) ? '0 : target - 1'b1;
  assign at_last  = (cnt == last_idx);
  assign acc_next = acc + AW'($signed(sum_in));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cnt       <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else if (flush) begin
      acc       <= '0;
      cnt       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (sum_vld) begin
        if (at_last) begin
          res_data  <= acc_next;
          res_valid <= 1'b1;
          acc       <= '0;
          cnt       <= '0;
        end else begin
          acc <= acc_next;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (acc == '0)); // R10

  AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cnt == '0)); // R6

endmodule

// File: rtl/gemv_lane.sv
module gemv_lane
  import gemv_lane_pkg::*;
#(
  parameter int N      = 32,
  parameter int WB     = 4,
  parameter int MANT_W = 8,
  parameter int CNT_W  = 17,
  localparam int OPW   = operand_width(MANT_W),
  localparam int PW    = product_width(OPW),
  localparam int SW    = tree_width(PW, N),
  localparam int AW    = SW + CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lane_en,
  input  logic [CNT_W-1:0]    num_vec,
  input  logic               feat_ready,
  input  logic [N*WB*OPW-1:0] feat_ops,
  input  logic               w_valid,
  input  logic [N*WB-1:0]     w_data,
  output logic               w_ready,
  output logic [AW-1:0]       res_data,
  output logic               res_valid
);

  logic              flush;
  logic              fire;
  logic [N*PW-1:0]    prods;
  logic              prod_vld;
  logic [SW-1:0]      root;
  logic              root_vld;

  assign flush   = !lane_en;
  assign w_ready = lane_en && feat_ready;
  assign fire    = w_valid && w_ready;

  gemv_lane_bitsel #(.N(N), .WB(WB), .OPW(OPW), .PW(PW)) u_bitsel (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .in_fire  (fire),
    .w_data   (w_data),
    .ops      (feat_ops),
    .prods    (prods),
    .prod_vld (prod_vld)
  );

  gemv_lane_tree #(.N(N), .PW(PW), .SW(SW)) u_tree (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .leaves   (prods),
    .leaf_vld (prod_vld),
    .root     (root),
    .root_vld (root_vld)
  );

  gemv_lane_accum #(.SW(SW), .CW(CNT_W), .AW(AW)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .sum_in    (root),
    .sum_vld   (root_vld),
    .target    (num_vec),
    .res_data  (res_data),
    .res_valid (res_valid)
  );

  AST_NO_RESULT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !lane_en |=> !res_valid); // R9

  AST_RESULT_FROM_TREE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(root_vld)); // R5

  AST_NO_FIRE_UNREADY: assert property (@(posedge clk) disable iff (rst)
    !feat_ready |=> !prod_vld); // R8

endmodule

// File: tb/gemv_lane_bench.sv
module gemv_lane_bench;
  localparam int N   = 32;
  localparam int WB  = 4;
  localparam int OPW = 11;
  localparam int CW  = 17;
  localparam int AW  = 35;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              lane_en = 1'b0;
  logic [CW-1:0]      num_vec = 17'd1;
  logic              feat_ready = 1'b0;
  logic [N*WB*OPW-1:0] feat_ops = '0;
  logic              w_valid = 1'b0;
  logic [N*WB-1:0]    w_data = '0;
  logic              w_ready;
  logic [AW-1:0]      res_data;
  logic              res_valid;

  gemv_lane u_gemv_lane (
    .clk(clk), .rst(rst), .lane_en(lane_en), .num_vec(num_vec),
    .feat_ready(feat_ready), .feat_ops(feat_ops), .w_valid(w_valid),
    .w_data(w_data), .w_ready(w_ready), .res_data(res_data), .res_valid(res_valid)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_drive = 0;
  int wv [0:N-1];
  int fv [0:N-1];
  longint got_val [0:255];
  int got_cyc [0:255];
  int n_got = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (res_valid && n_got < 256) begin
      got_val[n_got] = longint'($signed(res_data));
      got_cyc[n_got] = cyc;
      n_got = n_got + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint dot();
    longint s = 0;
    for (int i = 0; i < N; i++) s += longint'(wv[i]) * longint'(fv[i]);
    return s;
  endfunction

  task automatic fill(input int s, input int fs);
    for (int i = 0; i < N; i++) begin
      wv[i] = ((i + s) % 16) - 8;
      fv[i] = ((i * 37 + fs * 53) % 256) - 128;
    end
  endtask

  task automatic fill_const(input int w, input int f);
    for (int i = 0; i < N; i++) begin
      wv[i] = w;
      fv[i] = f;
    end
  endtask

  task automatic push();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      w_data[i*WB +: WB] = 4'(wv[i]);
      for (int b = 0; b < WB; b++)
        feat_ops[(i*WB+b)*OPW +: OPW] = OPW'(fv[i] * (1 << b));
    end
    w_valid = 1'b1;
    last_drive = cyc;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      w_valid = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    longint e;
    longint ev [0:7];

    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1 valid", longint'(res_valid), 0);
    check(res_data == '0, "R1 data", longint'($signed(res_data)), 0);
    rst = 1'b0;
    @(negedge clk);
    check(w_ready == 1'b0, "R2 ready off", longint'(w_ready), 0);
    lane_en = 1'b1;
    feat_ready = 1'b1;
    #1;
    check(w_ready == 1'b1, "R2 ready on", longint'(w_ready), 1);

    // R3 R5: full weight sweep, one vector per result
    num_vec = 17'd1;
    for (int s = 0; s < 16; s++) begin
      fill(s, s + 3);
      e = dot();
      base = n_got;
      push();
      idle(10);
      check(n_got == base + 1, "R5 pulse count", longint'(n_got - base), 1);
      check(got_val[base] == e, "R3 product sum", got_val[base], e);
      check(got_cyc[base] == last_drive + 7, "R5 latency",
            longint'(got_cyc[base] - last_drive), 7);
    end

    // R4: extremes
    fill_const(-8, -128); e = dot(); base = n_got; push(); idle(10);
    check(got_val[base] == e, "R4 max positive", got_val[base], e);
    fill_const(7, -128); e = dot(); base = n_got; push(); idle(10);
    check(got_val[base] == e, "R4 negative", got_val[base], e);
    fill_const(-8, 127); e = dot(); base = n_got; push(); idle(10);
    check(got_val[base] == e, "R4 most negative", got_val[base], e);

    // R7: back-to-back single-vector results
    base = n_got;
    for (int k = 0; k < 6; k++) begin
      fill(k * 5, k + 20);
      ev[k] = dot();
      push();
    end
    idle(12);
    check(n_got == base + 6, "R7 count", longint'(n_got - base), 6);
    for (int k = 0; k < 6; k++) begin
      check(got_val[base+k] == ev[k], "R7 value", got_val[base+k], ev[k]);
      if (k > 0)
        check(got_cyc[base+k] == got_cyc[base+k-1] + 1, "R7 spacing",
              longint'(got_cyc[base+k] - got_cyc[base+k-1]), 1);
    end

    // R6: five vectors with gaps, one result
    num_vec = 17'd5;
    base = n_got;
    e = 0;
    for (int k = 0; k < 5; k++) begin
      fill(k + 7, k * 3);
      e += dot();
      push();
      idle(k % 3);
    end
    idle(12);
    check(n_got == base + 1, "R6 group count", longint'(n_got - base), 1);
    check(got_val[base] == e, "R6 group sum", got_val[base], e);

    // R6: count 3, six back-to-back vectors, two results
    num_vec = 17'd3;
    base = n_got;
    ev[0] = 0;
    ev[1] = 0;
    for (int k = 0; k < 6; k++) begin
      fill(k + 2, k + 40);
      ev[k/3] += dot();
      push();
    end
    idle(12);
    check(n_got == base + 2, "R6 restart count", longint'(n_got - base), 2);
    check(got_val[base] == ev[0], "R6 first group", got_val[base], ev[0]);
    check(got_val[base+1] == ev[1], "R6 second group", got_val[base+1], ev[1]);

    // R6: zero count behaves as one
    num_vec = 17'd0;
    base = n_got;
    fill(1, 9); ev[0] = dot(); push();
    fill(4, 11); ev[1] = dot(); push();
    idle(12);
    check(n_got == base + 2, "R6 zero count", longint'(n_got - base), 2);
    check(got_val[base+1] == ev[1], "R6 zero value", got_val[base+1], ev[1]);

    // R10: consecutive groups of two stay separate
    num_vec = 17'd2;
    base = n_got;
    fill(3, 5); e = dot(); push();
    fill(6, 8); e += dot(); push();
    idle(12);
    fill(9, 13); ev[0] = dot(); push();
    fill(12, 17); ev[0] += dot(); push();
    idle(12);
    check(n_got == base + 2, "R10 count", longint'(n_got - base), 2);
    check(got_val[base] == e, "R10 first", got_val[base], e);
    check(got_val[base+1] == ev[0], "R10 second clean", got_val[base+1], ev[0]);

    // R8: feature not ready, offered weights ignored
    num_vec = 17'd1;
    base = n_got;
    fill(2, 2);
    push();
    feat_ready = 1'b0;
    #1;
    check(w_ready == 1'b0, "R8 ready low", longint'(w_ready), 0);
    repeat (10) @(negedge clk);
    idle(1);
    feat_ready = 1'b1;
    idle(10);
    check(n_got == base, "R8 no result", longint'(n_got - base), 0);

    // R9: flush in the middle of a group
    num_vec = 17'd3;
    base = n_got;
    fill(5, 30); push();
    fill(8, 31); push();
    @(negedge clk);
    w_valid = 1'b0;
    lane_en = 1'b0;
    #1;
    check(w_ready == 1'b0, "R9 ready low", longint'(w_ready), 0);
    idle(8);
    check(n_got == base, "R9 nothing while off", longint'(n_got - base), 0);
    lane_en = 1'b1;
    e = 0;
    for (int k = 0; k < 3; k++) begin
      fill(k + 11, k + 60);
      e += dot();
      push();
    end
    idle(12);
    check(n_got == base + 1, "R9 count after flush", longint'(n_got - base), 1);
    check(got_val[base] == e, "R9 discarded partial", got_val[base], e);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule